// File: doc/BRIEF.md
# Cascaded Host Interrupt Aggregator

This block gathers the error and event sources of a GPU command-host unit into a single 32-bit pending word. An enable word gates that pending word, and the result drives one interrupt line toward the CPU. Eight sources are latched straight into the pending word. Software clears each of them by writing 1 to its bit.

Three further bits of the pending word are not flags. Each is the live OR of a second-level register that holds one bit per unit: one register for memory-fault units, one for DMA engines and one for runlists. A write to the pending word cannot clear these three bits. Each one drops only after software has cleared every unit bit beneath it in its own second-level register. Software reads the raw pending word, the gated status, the enable word and the three unit registers through a small register port. The enable bit for the engine-event source has its own control address, so it can be switched on or off without a read-modify-write of the other enables.

Top module: `host_irq_aggr`

## Requirements
- R1: After reset, every readable register reads 0 and `irq_o` is low.
- R2: A pulse on `direct_evt_i[k]` sets a fixed bit of the raw pending word (address 0). Inputs k = 0..7 map to bits 0, 4, 8, 16, 23, 24, 27 and 31. Pending bits 1-3, 5-7, 9-15, 17-22, 25 and 26 always read 0.
- R3: A write to address 0 clears each direct pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: When a source pulse and a write-1-to-clear reach the same bit in the same cycle, the bit ends up set. This holds for both direct bits and unit bits.
- R5: A pulse on `fault_evt_i[u]` sets bit u of the fault unit register (address 2). A write to address 2 clears the unit bits written as 1. Pending bit 28 is the OR of that register.
- R6: A pulse on `dma_evt_i[u]` sets bit u of the DMA unit register (address 3). A write to address 3 clears the unit bits written as 1. Pending bit 29 is the OR of that register.
- R7: A pulse on `runl_evt_i[u]` sets bit u of the runlist register (address 4). A write to address 4 clears the unit bits written as 1. Pending bit 30 is the OR of that register. A write to address 0 never clears bits 28, 29 or 30.
- R8: Address 1 reads and writes the full enable word. Address 6 reads the raw pending word ANDed with the enable word.
- R9: A write to address 5 sets enable bit 31 to write-data bit 0 and leaves enable bits 30..0 unchanged.
- R10: `irq_o` is high in the cycle after any bit of (pending AND enable) is set, and low in the cycle after none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 pending, 1 enable, 2 fault, 3 DMA, 4 runlist, 5 event-enable control, 6 gated status) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| direct_evt_i | input | 8 | One-cycle pulses of the directly latched sources |
| fault_evt_i | input | NUM_FAULT | Per-unit memory-fault pulses |
| dma_evt_i | input | NUM_DMA | Per-unit DMA-engine pulses |
| runl_evt_i | input | NUM_RUNL | Per-runlist completion pulses |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that the register port is synchronous to `clk_i`. They also assume that each source input is a level sampled once per clock, so a source held high is treated as a new pulse on every cycle. The bench drives all inputs on the falling edge and holds each source pulse for exactly one cycle. It issues at most one register write per cycle and reads the combinational read data only when no write is in progress. Collisions between a set and a clear are created on purpose, by raising a source and a write strobe in the same cycle.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int N_DIRECT = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_PEND  = 3'd0,
    A_EN    = 3'd1,
    A_FAULT = 3'd2,
    A_DMA   = 3'd3,
    A_RUNL  = 3'd4,
    A_EVEN  = 3'd5,
    A_STAT  = 3'd6,
    A_RSVD  = 3'd7
  } reg_addr_e;

  // position of each direct source in the pending word
  localparam int DIRECT_POS [N_DIRECT] = '{0, 4, 8, 16, 23, 24, 27, 31};

  localparam int BIT_FAULT = 28;
  localparam int BIT_DMA   = 29;
  localparam int BIT_RUNL  = 30;
  localparam int BIT_EVT   = 31;
endpackage

// File: rtl/w1c_bank.sv
module w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_all_i,
  input  logic              wr_top_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o
);
  localparam int TOP = DATA_W - 1;
  logic [DATA_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (wr_all_i) en_q <= wdata_i;
    else if (wr_top_i) en_q <= {wdata_i[0], en_q[TOP-1:0]};
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] stat_i,
  output logic              irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |stat_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/host_irq_aggr.sv
module host_irq_aggr
  import host_irq_pkg::*;
#(
  parameter int NUM_FAULT = 8,
  parameter int NUM_DMA   = 8,
  parameter int NUM_RUNL  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [N_DIRECT-1:0]  direct_evt_i,
  input  logic [NUM_FAULT-1:0] fault_evt_i,
  input  logic [NUM_DMA-1:0]   dma_evt_i,
  input  logic [NUM_RUNL-1:0]  runl_evt_i,
  output logic                 irq_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr_i);

  logic wr_pend, wr_en, wr_fault, wr_dma, wr_runl, wr_even;
  assign wr_pend  = reg_wr_i && (addr == A_PEND);
  assign wr_en    = reg_wr_i && (addr == A_EN);
  assign wr_fault = reg_wr_i && (addr == A_FAULT);
  assign wr_dma   = reg_wr_i && (addr == A_DMA);
  assign wr_runl  = reg_wr_i && (addr == A_RUNL);
  assign wr_even  = reg_wr_i && (addr == A_EVEN);

  // direct sources
  logic [N_DIRECT-1:0] direct_clr, direct_q;
  for (genvar i = 0; i < N_DIRECT; i++) begin : g_dclr
    assign direct_clr[i] = wr_pend & reg_wdata_i[DIRECT_POS[i]];
  end

  w1c_bank #(.W(N_DIRECT)) u_direct (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(direct_evt_i), .clr_i(direct_clr), .q_o(direct_q)
  );

  // second-level unit registers
  logic [NUM_FAULT-1:0] fault_q;
  logic [NUM_DMA-1:0]   dma_q;
  logic [NUM_RUNL-1:0]  runl_q;

  w1c_bank #(.W(NUM_FAULT)) u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(fault_evt_i),
    .clr_i({NUM_FAULT{wr_fault}} & reg_wdata_i[NUM_FAULT-1:0]), .q_o(fault_q)
  );
  w1c_bank #(.W(NUM_DMA)) u_dma (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(dma_evt_i),
    .clr_i({NUM_DMA{wr_dma}} & reg_wdata_i[NUM_DMA-1:0]), .q_o(dma_q)
  );
  w1c_bank #(.W(NUM_RUNL)) u_runl (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(runl_evt_i),
    .clr_i({NUM_RUNL{wr_runl}} & reg_wdata_i[NUM_RUNL-1:0]), .q_o(runl_q)
  );

  // top-level pending word: latched direct bits plus live summaries
  logic [DATA_W-1:0] pend_w;
  always_comb begin
    pend_w = '0;
    for (int i = 0; i < N_DIRECT; i++) pend_w[DIRECT_POS[i]] = direct_q[i];
    pend_w[BIT_FAULT] = |fault_q;
    pend_w[BIT_DMA]   = |dma_q;
    pend_w[BIT_RUNL]  = |runl_q;
  end

  logic [DATA_W-1:0] en_w, stat_w;

  irq_enable_reg #(.DATA_W(DATA_W)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_all_i(wr_en), .wr_top_i(wr_even),
    .wdata_i(reg_wdata_i), .en_o(en_w)
  );

  assign stat_w = pend_w & en_w;

  irq_line #(.DATA_W(DATA_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .stat_i(stat_w), .irq_o(irq_o)
  );

  always_comb begin
    unique case (addr)
      A_PEND:  reg_rdata_o = pend_w;
      A_EN:    reg_rdata_o = en_w;
      A_FAULT: reg_rdata_o = DATA_W'(fault_q);
      A_DMA:   reg_rdata_o = DATA_W'(dma_q);
      A_RUNL:  reg_rdata_o = DATA_W'(runl_q);
      A_STAT:  reg_rdata_o = stat_w;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/host_irq_aggr_chk.sv
module host_irq_aggr_chk
  import host_irq_pkg::*;
#(
  parameter int NUM_FAULT = 8,
  parameter int NUM_DMA   = 8,
  parameter int NUM_RUNL  = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_wr_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [N_DIRECT-1:0]  direct_evt_i,
  input logic [NUM_FAULT-1:0] fault_evt_i,
  input logic [NUM_DMA-1:0]   dma_evt_i,
  input logic [NUM_RUNL-1:0]  runl_evt_i,
  input logic [DATA_W-1:0]    pend_w,
  input logic [DATA_W-1:0]    en_w,
  input logic                 irq_o
);
  a_r4_direct_lo_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_evt_i[0] |=> pend_w[0]);

  a_r4_direct_hi_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_evt_i[N_DIRECT-1] |=> pend_w[BIT_EVT]);

  a_r5_fault_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_evt_i) |=> pend_w[BIT_FAULT]);

  a_r6_dma_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dma_evt_i) |=> pend_w[BIT_DMA]);

  a_r7_runl_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|runl_evt_i) |=> pend_w[BIT_RUNL]);

  a_r7_no_top_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd0 && pend_w[BIT_RUNL]) |=> pend_w[BIT_RUNL]);

  a_r9_low_enables_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd5) |=> en_w[DATA_W-2:0] == $past(en_w[DATA_W-2:0]));

  a_r9_top_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd5) |=> en_w[DATA_W-1] == $past(reg_wdata_i[0]));

  a_r10_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(pend_w & en_w)));
endmodule

bind host_irq_aggr host_irq_aggr_chk #(
  .NUM_FAULT(NUM_FAULT), .NUM_DMA(NUM_DMA), .NUM_RUNL(NUM_RUNL)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .direct_evt_i(direct_evt_i), .fault_evt_i(fault_evt_i),
  .dma_evt_i(dma_evt_i), .runl_evt_i(runl_evt_i), .pend_w(pend_w), .en_w(en_w),
  .irq_o(irq_o)
);

// File: tb/host_irq_aggr_tb_top.sv
module host_irq_aggr_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic [31:0] reg_wdata_i = 32'd0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  direct_evt_i = 8'd0;
  logic [7:0]  fault_evt_i = 8'd0;
  logic [7:0]  dma_evt_i = 8'd0;
  logic [7:0]  runl_evt_i = 8'd0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  host_irq_aggr dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .direct_evt_i(direct_evt_i),
    .fault_evt_i(fault_evt_i), .dma_evt_i(dma_evt_i), .runl_evt_i(runl_evt_i),
    .irq_o(irq_o)
  );

  localparam int POS [8] = '{0, 4, 8, 16, 23, 24, 27, 31};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = 32'd0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic pulse(logic [7:0] d, logic [7:0] f, logic [7:0] m, logic [7:0] r);
    @(negedge clk_i);
    direct_evt_i = d; fault_evt_i = f; dma_evt_i = m; runl_evt_i = r;
    @(negedge clk_i);
    direct_evt_i = 8'd0; fault_evt_i = 8'd0; dma_evt_i = 8'd0; runl_evt_i = 8'd0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_chk("R1 reset value", 3'(a), 32'd0);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_init;
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h7FFF_FFFF);
    rd_chk("R8 enable readback", 3'd1, 32'h7FFF_FFFF);
  endtask

  task automatic t_direct;
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i), 8'd0, 8'd0, 8'd0);
      rd_chk("R2 direct map", 3'd0, 32'(1) << POS[i]);
      wr(3'd0, 32'hFFFF_FFFF);
    end
    pulse(8'hFF, 8'd0, 8'd0, 8'd0);
    rd_chk("R2 all direct, unused bits zero", 3'd0, 32'h8981_0111);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R3 clear all", 3'd0, 32'd0);
  endtask

  task automatic t_w1c;
    pulse(8'h03, 8'd0, 8'd0, 8'd0);
    wr(3'd0, 32'h0000_0010);
    rd_chk("R3 clear one bit", 3'd0, 32'h0000_0001);
    wr(3'd0, 32'h0000_0000);
    rd_chk("R3 zero write keeps", 3'd0, 32'h0000_0001);
    wr(3'd0, 32'h0000_0001);
    rd_chk("R3 clear last", 3'd0, 32'd0);
  endtask

  task automatic t_set_wins;
    pulse(8'h0C, 8'd0, 8'd0, 8'd0);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 32'h0001_0100;
    direct_evt_i = 8'h04;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = 32'd0; direct_evt_i = 8'd0;
    rd_chk("R4 direct set wins", 3'd0, 32'h0000_0100);
    wr(3'd0, 32'hFFFF_FFFF);
    pulse(8'd0, 8'd0, 8'h01, 8'd0);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = 3'd3; reg_wdata_i = 32'h0000_0001;
    dma_evt_i = 8'h01;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = 32'd0; dma_evt_i = 8'd0;
    rd_chk("R4 unit set wins", 3'd3, 32'h0000_0001);
    wr(3'd3, 32'h0000_00FF);
    rd_chk("R6 dma cleared", 3'd3, 32'd0);
  endtask

  task automatic t_fault;
    pulse(8'd0, 8'h05, 8'd0, 8'd0);
    rd_chk("R5 fault units", 3'd2, 32'h0000_0005);
    rd_chk("R5 fault summary", 3'd0, 32'h1000_0000);
    wr(3'd0, 32'h1000_0000);
    rd_chk("R5 top write ignored", 3'd0, 32'h1000_0000);
    wr(3'd2, 32'h0000_0001);
    rd_chk("R5 partial unit clear", 3'd2, 32'h0000_0004);
    rd_chk("R5 summary held", 3'd0, 32'h1000_0000);
    wr(3'd2, 32'h0000_0004);
    rd_chk("R5 summary drops", 3'd0, 32'd0);
  endtask

  task automatic t_dma;
    pulse(8'd0, 8'd0, 8'h82, 8'd0);
    rd_chk("R6 dma units", 3'd3, 32'h0000_0082);
    rd_chk("R6 dma summary", 3'd0, 32'h2000_0000);
    wr(3'd3, 32'h0000_0082);
    rd_chk("R6 dma summary drops", 3'd0, 32'd0);
  endtask

  task automatic t_runl;
    pulse(8'd0, 8'd0, 8'd0, 8'h80);
    rd_chk("R7 runlist units", 3'd4, 32'h0000_0080);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R7 top write ignored", 3'd0, 32'h4000_0000);
    wr(3'd4, 32'h0000_0080);
    rd_chk("R7 summary drops", 3'd0, 32'd0);
  endtask

  task automatic t_mask;
    pulse(8'h80, 8'd0, 8'd0, 8'd0);
    rd_chk("R8 raw has event", 3'd0, 32'h8000_0000);
    rd_chk("R8 gated status masked", 3'd6, 32'd0);
    @(negedge clk_i);
    chk("R10 masked no irq", {31'd0, irq_o}, 32'd0);
    wr(3'd5, 32'h0000_0001);
    rd_chk("R9 top enable set", 3'd1, 32'hFFFF_FFFF);
    rd_chk("R8 gated status", 3'd6, 32'h8000_0000);
    @(negedge clk_i);
    chk("R10 irq after unmask", {31'd0, irq_o}, 32'd1);
    wr(3'd5, 32'h0000_0000);
    rd_chk("R9 top enable cleared", 3'd1, 32'h7FFF_FFFF);
    wr(3'd0, 32'h8000_0000);
    @(negedge clk_i);
    chk("R10 irq gone", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_latency;
    pulse(8'h01, 8'd0, 8'd0, 8'd0);
    chk("R10 not yet high", {31'd0, irq_o}, 32'd0);
    @(negedge clk_i);
    chk("R10 high one cycle later", {31'd0, irq_o}, 32'd1);
    wr(3'd0, 32'h0000_0001);
    chk("R10 still high after clear", {31'd0, irq_o}, 32'd1);
    @(negedge clk_i);
    chk("R10 low one cycle later", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_init();
    t_direct();
    t_w1c();
    t_set_wins();
    t_fault();
    t_dma();
    t_runl();
    t_mask();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule